// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Full-Width Tag Check

This block is a lookup-and-refill unit for a direct-mapped cache over a 32-bit physical address space. Every cache entry holds exactly one 32-bit word, four even-parity bits (one per byte), a valid flag and a 20-bit tag. A requester presents a physical address with a read or a write. The block splits the address into a byte offset, an index and a tag. It reads the entry at the index, compares the tag, checks the parity and answers with a response that carries a hit flag and the word.

The number of index bits, `IDX_W`, is fixed when the block is built. It ranges from 10 (a 4 KB cache) to 16 (a 256 KB cache). The tag keeps its width whatever the cache size: it is always address bits [31:12]. With an index wider than 10 bits, the low tag bits duplicate index bits. They are stored and compared anyway.

When a read misses, the block fetches the word from a simple memory port and writes it into the entry. It then returns the word to the requester. Writes go straight through to memory. A write changes the cache entry only when that entry already holds the address.

Top module: `wcache_top`

## Requirements
- R1: Address bits [IDX_W+1:2] select the entry and address bits [31:12] form the tag. A hit requires a set valid flag and a stored 20-bit tag equal to all of bits [31:12]. Two addresses that differ only in bit 31 therefore do not hit each other.
- R2: Reset clears every valid flag. After reset, `req_ready` is 1 and `resp_valid`, `mem_req_valid` and `par_err` are 0. The first read of any address is a miss.
- R3: A read hit raises `resp_valid` with `resp_hit`=1 and the stored word on the second rising edge after the request is accepted. It issues no memory request.
- R4: A read miss issues one read on the memory port with `mem_req_write`=0 and `mem_addr` equal to the request address with bits [1:0] cleared. The block waits for `mem_req_ready` and then `mem_resp_valid`. It stores the word, the parity and the tag, and answers with `resp_hit`=0 and the fetched word. The next read of that address hits.
- R5: Two addresses with the same index and different tags evict each other.
- R6: Address bits [1:0] do not take part in the lookup. Addresses that differ only in those bits hit the same entry.
- R7: A write that hits replaces the stored word and generates fresh even parity, so the entry's byte plus its parity bit hold an even number of ones. The write is forwarded to memory with `mem_req_write`=1, the word-aligned address and the data, and the response carries `resp_hit`=1.
- R8: A write that misses is forwarded to memory with `resp_hit`=0 and leaves the cache unchanged. A later read of that address misses.
- R9: A tag match whose stored parity disagrees with the stored word is a miss. `par_err` pulses for exactly one cycle, and the entry is refilled from memory.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted with the same address and direction.
- R11: `req_ready` is low from the acceptance of a request until its response. A response appears only while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 32 | Write word |
| req_ready | output | 1 | Block idle and able to take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Lookup hit for this response |
| resp_rdata | output | 32 | Read word |
| par_err | output | 1 | One-cycle parity-mismatch flag |
| mem_req_valid | output | 1 | Memory request asserted |
| mem_req_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write word |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Memory read data present |
| mem_rdata | input | 32 | Memory read word |
| mem_rpar | input | 4 | Memory read parity, one bit per byte |

## Verification
The bench sends addresses that share an index but differ in tag. A design that compared too few tag bits would return a hit with the wrong word, and one that indexed with the byte bits would miss on sub-word offsets. It checks that a write miss leaves the cache unchanged: a design that allocated on writes would then hit on the next read. It feeds one refill with deliberately wrong parity. A design that trusted the tag alone would answer that word as a hit without flagging it. A stalled memory port tests that the request is held steady and that the requester is kept out while the block is busy.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 20;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT
  } wc_state_t;

  // tag field: the top TAG_W address bits, independent of cache size
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // even parity, one bit per byte lane
  function automatic logic [LANES-1:0] par_of(input logic [DATA_W-1:0] d);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:OFF_W] w);
    return {w, {OFF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/wc_store.sv
module wc_store
  import wc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_par,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_par
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = TAG_W + DATA_W + LANES;

  logic [ENT_W-1:0] ram [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [ENT_W-1:0] ent_q;

  // tag and data share one index: a single wide word per entry
  always_ff @(posedge clk) begin
    if (we) ram[wr_idx] <= {wr_tag, wr_par, wr_data};
    if (rd_en) ent_q <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (we) vld[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= vld[rd_idx];
    end
  end

  assign rd_tag  = ent_q[ENT_W-1 -: TAG_W];
  assign rd_par  = ent_q[DATA_W +: LANES];
  assign rd_data = ent_q[DATA_W-1:0];
endmodule

// File: rtl/wc_cmp.sv
module wc_cmp
  import wc_pkg::*;
(
  input  logic              ent_vld,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [DATA_W-1:0] ent_data,
  input  logic [LANES-1:0]  ent_par,
  input  logic [TAG_W-1:0]  want_tag,
  output logic              hit,
  output logic              perr
);
  logic tag_eq;
  logic par_ok;

  // full-width compare, redundant overlap bits included
  assign tag_eq = ent_vld && (ent_tag == want_tag);
  assign par_ok = (par_of(ent_data) == ent_par);
  assign hit    = tag_eq && par_ok;
  assign perr   = tag_eq && !par_ok;
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
  import wc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              lk_hit,
  input  logic              lk_perr,
  input  logic [DATA_W-1:0] lk_data,
  output logic [TAG_W-1:0]  q_tag,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              we,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_par,
  output logic              refill,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [LANES-1:0]  mem_rpar,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              par_err
);
  localparam int IDX_LSB = OFF_W;
  localparam int IDX_MSB = OFF_W + IDX_W - 1;

  wc_state_t             state;
  logic [ADDR_W-1:OFF_W] waddr_q;
  logic [DATA_W-1:0]     wdata_q;
  logic                  wr_q;
  logic                  hit_q;
  logic                  rv_q, rh_q, pe_q;
  logic [DATA_W-1:0]     rdata_q;
  logic                  wr_hit;
  logic                  unused_lo;

  assign unused_lo = ^req_addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      waddr_q <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      hit_q   <= 1'b0;
      rv_q    <= 1'b0;
      rh_q    <= 1'b0;
      pe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      rv_q <= 1'b0;
      pe_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          waddr_q <= req_addr[ADDR_W-1:OFF_W];
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          hit_q <= lk_hit;
          pe_q  <= lk_perr;
          if (!wr_q && lk_hit) begin
            rv_q    <= 1'b1;
            rh_q    <= 1'b1;
            rdata_q <= lk_data;
            state   <= ST_IDLE;
          end else begin
            state <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) begin
          if (wr_q) begin
            rv_q    <= 1'b1;
            rh_q    <= hit_q;
            rdata_q <= wdata_q;
            state   <= ST_IDLE;
          end else begin
            state <= ST_MWAIT;
          end
        end
        ST_MWAIT: if (mem_resp_valid) begin
          rv_q    <= 1'b1;
          rh_q    <= 1'b0;
          rdata_q <= mem_rdata;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rd_en     = req_ready && req_valid;
  assign rd_idx    = req_addr[IDX_MSB:IDX_LSB];
  assign q_tag     = tag_of(word_addr(waddr_q));

  assign wr_hit = (state == ST_LOOK) && wr_q && lk_hit;
  assign refill = (state == ST_MWAIT) && mem_resp_valid;

  always_comb begin
    we      = wr_hit || refill;
    wr_idx  = waddr_q[IDX_MSB:IDX_LSB];
    wr_tag  = q_tag;
    wr_data = refill ? mem_rdata : wdata_q;
    wr_par  = refill ? mem_rpar : par_of(wdata_q);
  end

  assign mem_req_valid = (state == ST_MREQ);
  assign mem_req_write = wr_q;
  assign mem_addr      = word_addr(waddr_q);
  assign mem_wdata     = wdata_q;

  assign resp_valid = rv_q;
  assign resp_hit   = rh_q;
  assign resp_rdata = rdata_q;
  assign par_err    = pe_q;
endmodule

// File: rtl/wcache_top.sv
module wcache_top
  import wc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic        resp_valid,
  output logic        resp_hit,
  output logic [31:0] resp_rdata,
  output logic        par_err,
  output logic        mem_req_valid,
  output logic        mem_req_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_req_ready,
  input  logic        mem_resp_valid,
  input  logic [31:0] mem_rdata,
  input  logic [3:0]  mem_rpar
);
  logic              rd_en, we, refill;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [TAG_W-1:0]  wr_tag, q_tag, ent_tag;
  logic [DATA_W-1:0] wr_data, ent_data;
  logic [LANES-1:0]  wr_par, ent_par;
  logic              ent_vld;
  logic              lk_hit, lk_perr;

  wc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .lk_hit(lk_hit), .lk_perr(lk_perr), .lk_data(ent_data), .q_tag(q_tag),
    .rd_en(rd_en), .rd_idx(rd_idx), .we(we), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_data(wr_data), .wr_par(wr_par), .refill(refill),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_req_ready(mem_req_ready),
    .mem_resp_valid(mem_resp_valid), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .par_err(par_err)
  );

  wc_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .we(we), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data), .wr_par(wr_par),
    .rd_vld(ent_vld), .rd_tag(ent_tag), .rd_data(ent_data), .rd_par(ent_par)
  );

  wc_cmp u_cmp (
    .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_data(ent_data), .ent_par(ent_par),
    .want_tag(q_tag), .hit(lk_hit), .perr(lk_perr)
  );
endmodule

// File: rtl/wc_chk.sv
module wc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_hit,
  input logic        par_err,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_addr,
  input logic        refill
);
  a_r9_perr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err);

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_addr) && $stable(mem_req_write));

  a_r11_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

  a_r11_busy_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r4_refill_resp: assert property (@(posedge clk) disable iff (!rst_n)
    refill |=> resp_valid && !resp_hit);
endmodule

bind wcache_top wc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .par_err(par_err), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_addr(mem_addr), .refill(refill)
);

// File: tb/wcache_top_test.sv
module wcache_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, resp_valid, resp_hit, par_err;
  logic [31:0] resp_rdata;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_rpar = '0;

  int checks = 0, errors = 0;
  int mem_lat = 1, mem_reads = 0, mem_writes = 0;
  bit bad_par = 1'b0, hold_bad = 1'b0, busy_bad = 1'b0;
  logic [31:0] last_waddr = '0, last_wdata = '0, a0;
  logic        w0;

  always #4 clk = ~clk;

  wcache_top uut (.*);

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h6B3C_91E5;
  endfunction

  function automatic logic [3:0] epar(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = d[8*i] ^ d[8*i+1] ^ d[8*i+2] ^ d[8*i+3]
                                     ^ d[8*i+4] ^ d[8*i+5] ^ d[8*i+6] ^ d[8*i+7];
    return p;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        a0 = mem_addr;
        w0 = mem_req_write;
        for (int i = 0; i < mem_lat; i++) begin
          @(negedge clk);
          if (!mem_req_valid || mem_addr !== a0 || mem_req_write !== w0) hold_bad = 1'b1;
        end
        mem_req_ready = 1'b1;
        if (w0) begin
          last_waddr = mem_addr;
          last_wdata = mem_wdata;
          mem_writes++;
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (!w0) begin
          mem_reads++;
          repeat (mem_lat) @(negedge clk);
          mem_resp_valid = 1'b1;
          mem_rdata = mword(a0);
          mem_rpar = epar(mword(a0)) ^ (bad_par ? 4'b0001 : 4'b0000);
          bad_par = 1'b0;
          @(negedge clk);
          mem_resp_valid = 1'b0;
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        output bit hit, output logic [31:0] rd, output int lat, output bit pe);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; pe = 1'b0;
    while (!resp_valid && lat < 200) begin
      if (req_ready) busy_bad = 1'b1;
      pe |= par_err;
      @(negedge clk);
      lat++;
    end
    pe |= par_err;
    hit = resp_hit;
    rd = resp_rdata;
  endtask

  task automatic t_reset_cold();
    bit h; logic [31:0] r; int l; bit p; int n;
    chk(req_ready === 1'b1, "R2 ready after reset", req_ready, 1);
    chk(resp_valid === 1'b0 && mem_req_valid === 1'b0 && par_err === 1'b0,
        "R2 quiet after reset", {resp_valid, mem_req_valid, par_err}, 0);
    n = mem_reads;
    access(1'b0, 32'h0000_1230, '0, h, r, l, p);
    chk(!h, "R2 cold read misses", h, 0);
    chk(mem_reads == n + 1, "R4 one memory read", mem_reads - n, 1);
    chk(r === mword(32'h0000_1230), "R4 fill data", r, mword(32'h0000_1230));
  endtask

  task automatic t_hit();
    bit h; logic [31:0] r; int l; bit p; int n;
    n = mem_reads;
    access(1'b0, 32'h0000_1230, '0, h, r, l, p);
    chk(h, "R4 reread hits", h, 1);
    chk(l == 2, "R3 hit latency", l, 2);
    chk(r === mword(32'h0000_1230), "R3 hit data", r, mword(32'h0000_1230));
    chk(mem_reads == n, "R3 no memory read", mem_reads - n, 0);
    access(1'b0, 32'h0000_1233, '0, h, r, l, p);
    chk(h && r === mword(32'h0000_1230), "R6 byte offset ignored", {31'b0, h}, 1);
  endtask

  task automatic t_tag();
    bit h; logic [31:0] r; int l; bit p;
    access(1'b0, 32'h8000_1230, '0, h, r, l, p);
    chk(!h, "R1 bit 31 differs misses", h, 0);
    chk(r === mword(32'h8000_1230), "R1 refill data", r, mword(32'h8000_1230));
  endtask

  task automatic t_conflict();
    bit h; logic [31:0] r; int l; bit p;
    access(1'b0, 32'h0000_0040, '0, h, r, l, p);
    access(1'b0, 32'h0000_1040, '0, h, r, l, p);
    chk(!h, "R5 conflicting tag misses", h, 0);
    access(1'b0, 32'h0000_0040, '0, h, r, l, p);
    chk(!h, "R5 evicted entry misses", h, 0);
    access(1'b0, 32'h0000_0040, '0, h, r, l, p);
    chk(h && r === mword(32'h0000_0040), "R5 refilled entry hits", {31'b0, h}, 1);
  endtask

  task automatic t_write_hit();
    bit h; logic [31:0] r; int l; bit p; int n;
    n = mem_writes;
    access(1'b1, 32'h0000_0042, 32'hA5C3_0F96, h, r, l, p);
    chk(h, "R7 write hit flag", h, 1);
    chk(mem_writes == n + 1 && last_waddr === 32'h0000_0040, "R7 write forwarded", last_waddr, 32'h40);
    chk(last_wdata === 32'hA5C3_0F96, "R7 forwarded data", last_wdata, 32'hA5C3_0F96);
    access(1'b0, 32'h0000_0040, '0, h, r, l, p);
    chk(h && !p && r === 32'hA5C3_0F96, "R7 updated word readable", r, 32'hA5C3_0F96);
  endtask

  task automatic t_write_miss();
    bit h; logic [31:0] r; int l; bit p; int n;
    n = mem_writes;
    access(1'b1, 32'h0000_2080, 32'h1234_5678, h, r, l, p);
    chk(!h, "R8 write miss flag", h, 0);
    chk(mem_writes == n + 1 && last_waddr === 32'h0000_2080, "R8 write forwarded", last_waddr, 32'h2080);
    access(1'b0, 32'h0000_2080, '0, h, r, l, p);
    chk(!h && r === mword(32'h0000_2080), "R8 no allocate", {31'b0, h}, 0);
  endtask

  task automatic t_parity();
    bit h; logic [31:0] r; int l; bit p; int n;
    bad_par = 1'b1;
    access(1'b0, 32'h0000_0300, '0, h, r, l, p);
    n = mem_reads;
    access(1'b0, 32'h0000_0300, '0, h, r, l, p);
    chk(p, "R9 parity flag", p, 1);
    chk(!h, "R9 parity error misses", h, 0);
    chk(mem_reads == n + 1, "R9 refill issued", mem_reads - n, 1);
    access(1'b0, 32'h0000_0300, '0, h, r, l, p);
    chk(h && !p, "R9 clean refill hits", {30'b0, h, p}, 2);
  endtask

  task automatic t_stall();
    bit h; logic [31:0] r; int l; bit p;
    mem_lat = 4;
    hold_bad = 1'b0; busy_bad = 1'b0;
    access(1'b0, 32'h0001_7F00, '0, h, r, l, p);
    access(1'b1, 32'h0001_7F04, 32'h0BAD_F00D, h, r, l, p);
    chk(!hold_bad, "R10 request held during stall", hold_bad, 0);
    chk(!busy_bad, "R11 ready low while busy", busy_bad, 0);
    access(1'b0, 32'h0001_7F00, '0, h, r, l, p);
    chk(h && r === mword(32'h0001_7F00), "R4 stalled fill hits", {31'b0, h}, 1);
    mem_lat = 1;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_cold();
    t_hit();
    t_tag();
    t_conflict();
    t_write_hit();
    t_write_miss();
    t_parity();
    t_stall();
    chk(!busy_bad, "R11 ready low in all runs", busy_bad, 0);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule